// File: doc/BRIEF.md
# SPI Register-Bank Slave with Burst and FIFO Streaming

This block is a 4-wire SPI slave that lets an external host read and write an internal byte-wide register bank. Every transaction opens with a header byte: a direction flag followed by a 7-bit register address. The data bytes that follow are either written through a register-bank write port or fetched through a register-bank read port and shifted back out on the serial output. The slave's side of the link runs in mode 0: the clock idles low, input is captured on the rising edge and output changes on the falling edge.

While the chip select stays low, the transfer continues as a burst. After each byte the address steps to the next register. One address is reserved as the FIFO data port. When a burst reaches it, the address stops stepping. During a read at that address, every completed byte pops the FIFO so that the next byte carries the next FIFO entry. The serial pins are oversampled by a faster system clock through synchronisers, so the SPI clock must stay high and low for at least six system clocks in each phase.

Top module: `spi_regbank_slave`

## Requirements
- R1: While chip select is high, `spi_miso_oe` and `spi_miso` are low and no write, read or pop strobe is issued.
- R2: Both directions shift most significant bit first. Header bit 7 selects the direction (1 = write, 0 = read) and header bits 6..0 carry the start address.
- R3: Input bits are captured on the rising SPI clock edge. A change on `spi_mosi` while the clock is high has no effect.
- R4: In a write, each completed data byte raises `reg_wr_en` for one cycle, with the current address on `reg_wr_addr` and the byte on `reg_wr_data`.
- R5: In a read, the slave pulses `reg_rd_en` with the address as soon as the header completes. The returned byte (valid on `reg_rd_data` the cycle after the strobe) is driven out on the next eight falling SPI clock edges. Input bits received during a read never cause a write.
- R6: In a burst, the address steps by one after every completed data byte, in both reads and writes. Address 7Eh steps to the FIFO address 7Fh.
- R7: In a read at the FIFO address 7Fh, the address does not step. Each completed byte raises `fifo_pop` for one cycle, and the cycle after that the slave issues a new read of 7Fh, so the next byte carries the next FIFO entry.
- R8: In a write at the FIFO address 7Fh, the address holds and `fifo_pop` stays low.
- R9: Raising chip select before a byte completes discards that byte without a write. The next transaction starts again with a header byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_oe | output | 1 | Output enable for the serial data pad |
| reg_wr_en | output | 1 | Register-bank write strobe |
| reg_wr_addr | output | 7 | Register-bank write address |
| reg_wr_data | output | 8 | Register-bank write data |
| reg_rd_en | output | 1 | Register-bank read strobe |
| reg_rd_addr | output | 7 | Register-bank read address |
| reg_rd_data | input | 8 | Read data, valid the cycle after the strobe |
| fifo_pop | output | 1 | Advances the receive FIFO by one entry |

## Verification
The bench targets four boundaries. The first is the step from 7Eh to 7Fh inside a read burst, where a design that keeps stepping or pops too early returns the wrong FIFO entry or skips one. The second is a write burst that crosses into the FIFO address: a design that wraps there would send the third byte to 00h, and one that confuses direction would pop the FIFO. The third is a transaction cut short mid-byte and followed by a fresh one; keeping stale bit counts would misread the new header. The fourth is an input that toggles while the clock is high and an all-ones byte sent during a read, which catch sampling on the wrong edge and writes that leak out of a read.

// File: rtl/spi_rb_pkg.sv
package spi_rb_pkg;
    localparam int SPI_AW = 7;
    localparam int SPI_DW = 8;
    localparam int SPI_BW = $clog2(SPI_DW);

    typedef struct packed {
        logic              in_hdr;
        logic              is_rd;
        logic [SPI_BW-1:0] bit_cnt;
        logic [SPI_AW-1:0] addr;
        logic [SPI_DW-2:0] rx_sh;
        logic [SPI_DW-1:0] tx_sh;
        logic              miso;
        logic              pop_pend;
        logic [1:0]        rd_wait;
        logic              wr_en;
        logic [SPI_AW-1:0] wr_addr;
        logic [SPI_DW-1:0] wr_data;
        logic              rd_en;
        logic [SPI_AW-1:0] rd_addr;
        logic              pop;
    } spi_rb_state_t;
endpackage

// File: rtl/spi_rb_sync.sv
module spi_rb_sync #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[0] <= RST_VAL;
        else        stg_q[0] <= din;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[s] <= RST_VAL;
            else        stg_q[s] <= stg_q[s-1];
        end
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/spi_rb_edge.sv
module spi_rb_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise,
    output logic fall
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl;
    end

    assign rise = lvl & ~prev_q;
    assign fall = ~lvl & prev_q;
endmodule

// File: rtl/spi_regbank_slave.sv
module spi_regbank_slave
    import spi_rb_pkg::*;
#(
    parameter logic [SPI_AW-1:0] FIFO_ADDR   = 7'h7F,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sclk,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    output logic              reg_wr_en,
    output logic [SPI_AW-1:0] reg_wr_addr,
    output logic [SPI_DW-1:0] reg_wr_data,
    output logic              reg_rd_en,
    output logic [SPI_AW-1:0] reg_rd_addr,
    input  logic [SPI_DW-1:0] reg_rd_data,
    output logic              fifo_pop
);
    localparam logic [SPI_BW-1:0] LAST_BIT = SPI_BW'(SPI_DW - 1);
    localparam logic [SPI_AW-1:0] ADDR_ONE = SPI_AW'(1);

    logic       sclk_s, cs_n_s, mosi_s;
    logic       sclk_rise, sclk_fall;
    logic       cs_act;
    spi_rb_state_t st_d, st_q;

    spi_rb_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({spi_sclk, spi_cs_n, spi_mosi}),
        .dout ({sclk_s, cs_n_s, mosi_s})
    );

    spi_rb_edge u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (sclk_s),
        .rise (sclk_rise),
        .fall (sclk_fall)
    );

    assign cs_act = ~cs_n_s;

    always_comb begin
        logic [SPI_DW-1:0] byte_in;
        byte_in        = {st_q.rx_sh, mosi_s};
        st_d           = st_q;
        st_d.wr_en     = 1'b0;
        st_d.rd_en     = 1'b0;
        st_d.pop       = 1'b0;
        st_d.rd_wait   = {st_q.rd_wait[0], 1'b0};
        if (!cs_act) begin
            st_d.in_hdr   = 1'b1;
            st_d.is_rd    = 1'b0;
            st_d.bit_cnt  = '0;
            st_d.rx_sh    = '0;
            st_d.tx_sh    = '0;
            st_d.miso     = 1'b0;
            st_d.pop_pend = 1'b0;
            st_d.rd_wait  = '0;
        end else begin
            // returned read data lands in the output shifter
            if (st_q.rd_wait[1]) st_d.tx_sh = reg_rd_data;
            // FIFO re-read one cycle after the pop
            if (st_q.pop_pend) begin
                st_d.pop_pend   = 1'b0;
                st_d.rd_en      = 1'b1;
                st_d.rd_addr    = st_q.addr;
                st_d.rd_wait[0] = 1'b1;
            end
            if (sclk_fall && !st_q.in_hdr && st_q.is_rd) begin
                st_d.miso  = st_q.tx_sh[SPI_DW-1];
                st_d.tx_sh = {st_q.tx_sh[SPI_DW-2:0], 1'b0};
            end
            if (sclk_rise) begin
                st_d.bit_cnt = st_q.bit_cnt + SPI_BW'(1);
                st_d.rx_sh   = byte_in[SPI_DW-2:0];
                if (st_q.bit_cnt == LAST_BIT) begin
                    if (st_q.in_hdr) begin
                        st_d.in_hdr = 1'b0;
                        st_d.is_rd  = ~byte_in[SPI_DW-1];
                        st_d.addr   = byte_in[SPI_AW-1:0];
                        if (!byte_in[SPI_DW-1]) begin
                            st_d.rd_en      = 1'b1;
                            st_d.rd_addr    = byte_in[SPI_AW-1:0];
                            st_d.rd_wait[0] = 1'b1;
                        end
                    end else if (st_q.is_rd) begin
                        if (st_q.addr == FIFO_ADDR) begin
                            st_d.pop      = 1'b1;
                            st_d.pop_pend = 1'b1;
                        end else begin
                            st_d.addr       = st_q.addr + ADDR_ONE;
                            st_d.rd_en      = 1'b1;
                            st_d.rd_addr    = st_q.addr + ADDR_ONE;
                            st_d.rd_wait[0] = 1'b1;
                        end
                    end else begin
                        st_d.wr_en   = 1'b1;
                        st_d.wr_addr = st_q.addr;
                        st_d.wr_data = byte_in;
                        if (st_q.addr != FIFO_ADDR) st_d.addr = st_q.addr + ADDR_ONE;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.in_hdr <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign spi_miso    = st_q.miso & cs_act;
    assign spi_miso_oe = cs_act;
    assign reg_wr_en   = st_q.wr_en;
    assign reg_wr_addr = st_q.wr_addr;
    assign reg_wr_data = st_q.wr_data;
    assign reg_rd_en   = st_q.rd_en;
    assign reg_rd_addr = st_q.rd_addr;
    assign fifo_pop    = st_q.pop;

    // R1: no strobes once the select has been inactive
    p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cs_act) |-> (!reg_wr_en && !reg_rd_en && !fifo_pop));

    // R5: a read transfer never produces a write in the same cycle as a read
    p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr_en && reg_rd_en));

    // R5: serial output only moves after a falling clock edge
    p_miso_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_act && $past(cs_act) && !$past(sclk_fall)) |-> $stable(spi_miso));

    // R7: every pop is followed by a re-read of the FIFO address
    p_pop_reread_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_pop && cs_act) |=> (reg_rd_en && reg_rd_addr == FIFO_ADDR));

    // R8: writes never pop
    p_no_pop_on_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |-> !fifo_pop);
endmodule

// File: tb/spi_regbank_slave_tb_top.sv
module spi_regbank_slave_tb_top;
    localparam int HALF     = 8;
    localparam int WD_LIMIT = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk = 1'b0;
    logic       csn = 1'b1;
    logic       mosi = 1'b0;
    logic       miso, miso_oe;
    logic       wr_en, rd_en, pop;
    logic [6:0] wr_addr, rd_addr;
    logic [7:0] wr_data;
    logic [7:0] bank_q = 8'h00;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int wr_cnt = 0;
    int pop_cnt = 0;
    int head   = 0;
    logic [6:0] log_a [64];
    logic [7:0] log_d [64];

    always #2.5 clk = ~clk;

    spi_regbank_slave dut_i (
        .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(csn), .spi_mosi(mosi),
        .spi_miso(miso), .spi_miso_oe(miso_oe),
        .reg_wr_en(wr_en), .reg_wr_addr(wr_addr), .reg_wr_data(wr_data),
        .reg_rd_en(rd_en), .reg_rd_addr(rd_addr), .reg_rd_data(bank_q),
        .fifo_pop(pop)
    );

    function automatic logic [7:0] reg_val(input logic [6:0] a);
        return {1'b0, a} ^ 8'h5A;
    endfunction

    function automatic logic [7:0] fifo_val(input int h);
        return 8'hC0 + 8'(h);
    endfunction

    // bank and FIFO model
    always @(posedge clk) begin
        if (rd_en) bank_q <= (rd_addr == 7'h7F) ? fifo_val(head) : reg_val(rd_addr);
        if (pop) begin head <= head + 1; pop_cnt <= pop_cnt + 1; end
        if (wr_en) begin log_a[wr_cnt % 64] = wr_addr; log_d[wr_cnt % 64] = wr_data; wr_cnt = wr_cnt + 1; end
    end

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc == WD_LIMIT) begin
            checks = checks + 1; fails = fails + 1;
            $display("FAIL watchdog: run did not finish, actual %0d cycles expected < %0d", cyc, WD_LIMIT);
            report();
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic xfer_byte(input logic [7:0] tx, input bit flip, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            mosi = tx[i];
            repeat (HALF) @(negedge clk);
            rx[i] = miso;
            sclk = 1'b1;
            repeat (HALF/2) @(negedge clk);
            if (flip) mosi = ~tx[i];
            repeat (HALF - HALF/2) @(negedge clk);
            sclk = 1'b0;
        end
    endtask

    task automatic txn_start();
        csn = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic txn_end();
        repeat (HALF) @(negedge clk);
        csn = 1'b1;
        repeat (3*HALF) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 oe idle", miso_oe, 0);
        chk("R1 miso idle", miso, 0);
        chk("R1 no writes", wr_cnt, 0);
        chk("R1 no pops", pop_cnt, 0);
    endtask

    task automatic t_single_write();
        logic [7:0] rx;
        int base = wr_cnt;
        txn_start();
        xfer_byte(8'h92, 0, rx);
        xfer_byte(8'h3C, 0, rx);
        txn_end();
        chk("R4 write count", wr_cnt - base, 1);
        chk("R2 write addr", log_a[base], 7'h12);
        chk("R4 write data", log_d[base], 8'h3C);
    endtask

    task automatic t_burst_write_flip();
        logic [7:0] rx;
        int base = wr_cnt;
        txn_start();
        xfer_byte(8'hA0, 1, rx);
        xfer_byte(8'h01, 1, rx);
        xfer_byte(8'hF2, 1, rx);
        xfer_byte(8'h6B, 1, rx);
        txn_end();
        chk("R6 burst count", wr_cnt - base, 3);
        chk("R3 addr0", log_a[base], 7'h20);
        chk("R3 data0", log_d[base], 8'h01);
        chk("R6 addr1", log_a[base+1], 7'h21);
        chk("R3 data1", log_d[base+1], 8'hF2);
        chk("R6 addr2", log_a[base+2], 7'h22);
        chk("R3 data2", log_d[base+2], 8'h6B);
    endtask

    task automatic t_single_read();
        logic [7:0] rx;
        int base = wr_cnt;
        txn_start();
        chk("R1 oe active", miso_oe, 1);
        xfer_byte(8'h05, 0, rx);
        xfer_byte(8'hFF, 0, rx);
        txn_end();
        chk("R5 read data", rx, reg_val(7'h05));
        chk("R5 no write in read", wr_cnt - base, 0);
    endtask

    task automatic t_read_into_fifo();
        logic [7:0] rx;
        int p0 = pop_cnt;
        txn_start();
        xfer_byte(8'h7D, 0, rx);
        xfer_byte(8'h00, 0, rx); chk("R6 rd 7D", rx, reg_val(7'h7D));
        xfer_byte(8'h00, 0, rx); chk("R6 rd 7E", rx, reg_val(7'h7E));
        xfer_byte(8'h00, 0, rx); chk("R7 fifo e0", rx, fifo_val(0));
        xfer_byte(8'h00, 0, rx); chk("R7 fifo e1", rx, fifo_val(1));
        txn_end();
        chk("R7 pops", pop_cnt - p0, 2);
    endtask

    task automatic t_fifo_burst();
        logic [7:0] rx;
        int p0 = pop_cnt;
        txn_start();
        xfer_byte(8'h7F, 0, rx);
        xfer_byte(8'h00, 0, rx); chk("R7 fifo e2", rx, fifo_val(2));
        xfer_byte(8'h00, 0, rx); chk("R7 fifo e3", rx, fifo_val(3));
        xfer_byte(8'h00, 0, rx); chk("R7 fifo e4", rx, fifo_val(4));
        txn_end();
        chk("R7 pops burst", pop_cnt - p0, 3);
    endtask

    task automatic t_write_into_fifo();
        logic [7:0] rx;
        int base = wr_cnt;
        int p0 = pop_cnt;
        txn_start();
        xfer_byte(8'hFE, 0, rx);
        xfer_byte(8'h11, 0, rx);
        xfer_byte(8'h22, 0, rx);
        xfer_byte(8'h33, 0, rx);
        txn_end();
        chk("R8 count", wr_cnt - base, 3);
        chk("R6 addr 7E", log_a[base], 7'h7E);
        chk("R8 addr 7F a", log_a[base+1], 7'h7F);
        chk("R8 addr 7F b", log_a[base+2], 7'h7F);
        chk("R8 data", log_d[base+2], 8'h33);
        chk("R8 no pop", pop_cnt - p0, 0);
    endtask

    task automatic t_abort();
        logic [7:0] rx;
        int base = wr_cnt;
        txn_start();
        xfer_byte(8'hB0, 0, rx);
        for (int i = 7; i >= 4; i--) begin
            mosi = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
        txn_end();
        chk("R9 aborted no write", wr_cnt - base, 0);
        txn_start();
        xfer_byte(8'hB1, 0, rx);
        xfer_byte(8'h77, 0, rx);
        txn_end();
        chk("R9 fresh count", wr_cnt - base, 1);
        chk("R9 fresh addr", log_a[base], 7'h31);
        chk("R9 fresh data", log_d[base], 8'h77);
        chk("R1 oe after", miso_oe, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_single_write();
        t_burst_write_flip();
        t_single_read();
        t_read_into_fifo();
        t_fifo_burst();
        t_write_into_fifo();
        t_abort();
        report();
    end
endmodule